// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer with Exception Redirect

This block is the state machine that steers a shared-ALU, shared-memory processor datapath through each instruction. It decodes a 6-bit opcode and a 6-bit function field and watches the ALU overflow flag. In every state it drives all multiplexer selects, register write enables, memory strobes and the two-bit ALU operation class. A small ALU decoder turns that operation class into a 4-bit ALU function code. Every instruction starts with a fetch state and a decode state. After that it takes a path set by its class: loads take 5 cycles, stores and register-register operations take 4, and branches and jumps take 3. The machine then returns to fetch.

The sequencer handles two exception conditions without leaving the state machine. The first is an opcode it does not recognise. The second is arithmetic overflow at the end of a register-register execute state. In both cases it enters an exception state that does three things. It has the datapath compute PC−4 and store that value as the faulting instruction's address. It writes a cause code. It loads a fixed vector into the PC: 0xC0000000 for an undefined instruction, 0xC0000020 for overflow. The datapath uses the cause code to pick between these two vectors. All outputs are decoded from the state register alone, so they are constant for the whole cycle.

Top module: `mc_ctl`

## Requirements
- R1: A synchronous, active-high reset puts the machine in fetch on the next rising edge, whatever state it was in.
- R2: Fetch drives mem_rd=1, ir_we=1, i_or_d=0, pc_we=1, src_a=0, src_b=01, alu_op=00, pc_src=00, and every other control output 0.
- R3: Decode drives src_a=0, src_b=11, alu_op=00, and every other control output 0. In decode, opcode 0x23 is load, 0x2B is store, 0x00 is register-register, 0x04 is branch-if-equal and 0x02 is jump.
- R4: Load and store both pass through an address state with src_a=1, src_b=10 and alu_op=00. A load then has a read state (mem_rd=1, i_or_d=1) and a write-back state (reg_we=1, reg_dst=0, mem_to_reg=1). A store then has one write state (mem_wr=1, i_or_d=1).
- R5: Register-register execute drives src_a=1, src_b=00 and alu_op=10. The next state, when there is no overflow, drives reg_we=1, reg_dst=1 and mem_to_reg=0.
- R6: Branch completion drives src_a=1, src_b=00, alu_op=01, pc_cond=1 and pc_src=01.
- R7: Jump completion drives pc_we=1 and pc_src=10.
- R8: Cycle counts are 5 for load, 4 for store, 4 for register-register, 3 for branch and 3 for jump. After the last state the machine is back in fetch.
- R9: Any other opcode in decode leads to the undefined-instruction state. That state drives epc_we=1, cause_we=1, cause_code=0, pc_we=1, pc_src=11, src_a=0, src_b=01 and alu_op=01, and is followed by fetch.
- R10: If ovf is high at the edge that ends register-register execute, write-back is skipped. The machine enters the overflow state instead, which drives the same outputs as R9 but with cause_code=1, and is then followed by fetch. ovf has no effect in any other state.
- R11: alu_ctl is 0010 (add) for alu_op=00 and 0110 (subtract) for alu_op=01. For alu_op=10 it is decoded from funct: 0x20 gives 0010, 0x22 gives 0110, 0x24 gives 0000, 0x25 gives 0001, 0x2A gives 0111, and any other funct gives 0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function field of the instruction register |
| ovf | input | 1 | ALU overflow flag |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| i_or_d | output | 1 | Memory address select: 0 = PC, 1 = ALU result register |
| ir_we | output | 1 | Instruction register write enable |
| pc_we | output | 1 | Unconditional PC write |
| pc_cond | output | 1 | PC write when the ALU zero flag is set |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target, 11 exception vector |
| src_a | output | 1 | ALU A select: 0 = PC, 1 = register A |
| src_b | output | 2 | ALU B select: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_op | output | 2 | ALU operation class |
| alu_ctl | output | 4 | Decoded ALU function code |
| reg_we | output | 1 | Register file write enable |
| reg_dst | output | 1 | Destination register select: 1 = rd, 0 = rt |
| mem_to_reg | output | 1 | Write-back source: 1 = memory data register |
| epc_we | output | 1 | Exception PC register write enable |
| cause_we | output | 1 | Cause register write enable |
| cause_code | output | 1 | Cause value: 0 = undefined instruction, 1 = overflow |

## Verification
Every control output is a pure decode of the state register. Each output's value is therefore due in the cycle the machine enters the matching state, which is one rising edge after the decision that leads there. The bench holds opcode and funct steady for the whole instruction and checks the full control vector at the falling edge of every cycle. It also checks alu_ctl in the execute and branch states. ovf is driven at a falling edge, so it is sampled at the next rising edge. The bench sets ovf during execute and reads the next state one falling edge later, and it toggles ovf at random in every other state to confirm that it has no effect there. Reset is checked one edge after it is applied in mid-instruction.

// File: rtl/mc_ctl_pkg.sv
package mc_ctl_pkg;

    localparam int OPC_W  = 6;
    localparam int FN_W   = 6;
    localparam int ACTL_W = 4;
    localparam int SEL_W  = 2;

    typedef enum logic [3:0] {
        S_FETCH, S_DECODE, S_MEMADR, S_MEMRD, S_MEMWB, S_MEMWR,
        S_REXEC, S_RWB, S_BRANCH, S_JUMP, S_XUNDEF, S_XOVF
    } state_e;

    localparam logic [OPC_W-1:0] OP_LW  = 6'h23;
    localparam logic [OPC_W-1:0] OP_SW  = 6'h2B;
    localparam logic [OPC_W-1:0] OP_RR  = 6'h00;
    localparam logic [OPC_W-1:0] OP_BEQ = 6'h04;
    localparam logic [OPC_W-1:0] OP_J   = 6'h02;

    localparam logic [SEL_W-1:0] SRCB_REG   = 2'b00;
    localparam logic [SEL_W-1:0] SRCB_FOUR  = 2'b01;
    localparam logic [SEL_W-1:0] SRCB_IMM   = 2'b10;
    localparam logic [SEL_W-1:0] SRCB_IMMSH = 2'b11;

    localparam logic [SEL_W-1:0] PCS_ALU = 2'b00;
    localparam logic [SEL_W-1:0] PCS_OUT = 2'b01;
    localparam logic [SEL_W-1:0] PCS_JMP = 2'b10;
    localparam logic [SEL_W-1:0] PCS_VEC = 2'b11;

    localparam logic [SEL_W-1:0] AOP_ADD = 2'b00;
    localparam logic [SEL_W-1:0] AOP_SUB = 2'b01;
    localparam logic [SEL_W-1:0] AOP_FN  = 2'b10;

    localparam logic [ACTL_W-1:0] ACTL_AND = 4'b0000;
    localparam logic [ACTL_W-1:0] ACTL_OR  = 4'b0001;
    localparam logic [ACTL_W-1:0] ACTL_ADD = 4'b0010;
    localparam logic [ACTL_W-1:0] ACTL_SUB = 4'b0110;
    localparam logic [ACTL_W-1:0] ACTL_SLT = 4'b0111;

    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;
    localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

    localparam logic CAUSE_UNDEF = 1'b0;
    localparam logic CAUSE_OVF   = 1'b1;

    typedef struct packed {
        logic              mem_rd;
        logic              mem_wr;
        logic              i_or_d;
        logic              ir_we;
        logic              pc_we;
        logic              pc_cond;
        logic [SEL_W-1:0]  pc_src;
        logic              src_a;
        logic [SEL_W-1:0]  src_b;
        logic [SEL_W-1:0]  alu_op;
        logic              reg_we;
        logic              reg_dst;
        logic              mem_to_reg;
        logic              epc_we;
        logic              cause_we;
        logic              cause_code;
    } ctl_s;

    function automatic state_e dispatch(input logic [OPC_W-1:0] op);
        case (op)
            OP_LW, OP_SW: return S_MEMADR;
            OP_RR:        return S_REXEC;
            OP_BEQ:       return S_BRANCH;
            OP_J:         return S_JUMP;
            default:      return S_XUNDEF;
        endcase
    endfunction

    function automatic logic op_known(input logic [OPC_W-1:0] op);
        return (op == OP_LW) || (op == OP_SW) || (op == OP_RR) ||
               (op == OP_BEQ) || (op == OP_J);
    endfunction

endpackage

// File: rtl/mc_ctl_next.sv
module mc_ctl_next
    import mc_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic             ovf,
    output state_e           state_q
);

    state_e state_d;

    always_comb begin
        case (state_q)
            S_FETCH:  state_d = S_DECODE;
            S_DECODE: state_d = dispatch(opcode);
            S_MEMADR: state_d = (opcode == OP_LW) ? S_MEMRD : S_MEMWR;
            S_MEMRD:  state_d = S_MEMWB;
            S_REXEC:  state_d = ovf ? S_XOVF : S_RWB;
            default:  state_d = S_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_FETCH;
        else     state_q <= state_d;
    end

    assert_fetch_decode_R8: assert property (@(posedge clk) disable iff (rst)
        state_q == S_FETCH |=> state_q == S_DECODE);

    assert_undef_entry_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_DECODE && !op_known(opcode)) |=> state_q == S_XUNDEF);

    assert_ovf_entry_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_REXEC && ovf) |=> state_q == S_XOVF);

    assert_exc_return_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_XUNDEF || state_q == S_XOVF) |=> state_q == S_FETCH);

endmodule

// File: rtl/mc_ctl_out.sv
module mc_ctl_out
    import mc_ctl_pkg::*;
(
    input  state_e state_q,
    output ctl_s   ctl
);

    always_comb begin
        ctl = '0;
        case (state_q)
            S_FETCH: begin
                ctl.mem_rd = 1'b1;
                ctl.ir_we  = 1'b1;
                ctl.pc_we  = 1'b1;
                ctl.src_b  = SRCB_FOUR;
                ctl.alu_op = AOP_ADD;
                ctl.pc_src = PCS_ALU;
            end
            S_DECODE: begin
                ctl.src_b  = SRCB_IMMSH;
                ctl.alu_op = AOP_ADD;
            end
            S_MEMADR: begin
                ctl.src_a  = 1'b1;
                ctl.src_b  = SRCB_IMM;
                ctl.alu_op = AOP_ADD;
            end
            S_MEMRD: begin
                ctl.mem_rd = 1'b1;
                ctl.i_or_d = 1'b1;
            end
            S_MEMWB: begin
                ctl.reg_we     = 1'b1;
                ctl.mem_to_reg = 1'b1;
            end
            S_MEMWR: begin
                ctl.mem_wr = 1'b1;
                ctl.i_or_d = 1'b1;
            end
            S_REXEC: begin
                ctl.src_a  = 1'b1;
                ctl.src_b  = SRCB_REG;
                ctl.alu_op = AOP_FN;
            end
            S_RWB: begin
                ctl.reg_we  = 1'b1;
                ctl.reg_dst = 1'b1;
            end
            S_BRANCH: begin
                ctl.src_a   = 1'b1;
                ctl.src_b   = SRCB_REG;
                ctl.alu_op  = AOP_SUB;
                ctl.pc_cond = 1'b1;
                ctl.pc_src  = PCS_OUT;
            end
            S_JUMP: begin
                ctl.pc_we  = 1'b1;
                ctl.pc_src = PCS_JMP;
            end
            S_XUNDEF, S_XOVF: begin
                ctl.epc_we     = 1'b1;
                ctl.cause_we   = 1'b1;
                ctl.cause_code = (state_q == S_XOVF) ? CAUSE_OVF : CAUSE_UNDEF;
                ctl.pc_we      = 1'b1;
                ctl.pc_src     = PCS_VEC;
                ctl.src_b      = SRCB_FOUR;
                ctl.alu_op     = AOP_SUB;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/mc_alu_dec.sv
module mc_alu_dec
    import mc_ctl_pkg::*;
(
    input  logic [SEL_W-1:0]  alu_op,
    input  logic [FN_W-1:0]   funct,
    output logic [ACTL_W-1:0] alu_ctl
);

    always_comb begin
        case (alu_op)
            AOP_SUB: alu_ctl = ACTL_SUB;
            AOP_FN: begin
                case (funct)
                    FN_SUB:  alu_ctl = ACTL_SUB;
                    FN_AND:  alu_ctl = ACTL_AND;
                    FN_OR:   alu_ctl = ACTL_OR;
                    FN_SLT:  alu_ctl = ACTL_SLT;
                    default: alu_ctl = ACTL_ADD;
                endcase
            end
            default: alu_ctl = ACTL_ADD;
        endcase
    end

endmodule

// File: rtl/mc_ctl.sv
module mc_ctl
    import mc_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [FN_W-1:0]   funct,
    input  logic              ovf,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              i_or_d,
    output logic              ir_we,
    output logic              pc_we,
    output logic              pc_cond,
    output logic [SEL_W-1:0]  pc_src,
    output logic              src_a,
    output logic [SEL_W-1:0]  src_b,
    output logic [SEL_W-1:0]  alu_op,
    output logic [ACTL_W-1:0] alu_ctl,
    output logic              reg_we,
    output logic              reg_dst,
    output logic              mem_to_reg,
    output logic              epc_we,
    output logic              cause_we,
    output logic              cause_code
);

    state_e state_q;
    ctl_s   ctl;

    mc_ctl_next u_next (
        .clk     (clk),
        .rst     (rst),
        .opcode  (opcode),
        .ovf     (ovf),
        .state_q (state_q)
    );

    mc_ctl_out u_out (
        .state_q (state_q),
        .ctl     (ctl)
    );

    mc_alu_dec u_alu (
        .alu_op  (ctl.alu_op),
        .funct   (funct),
        .alu_ctl (alu_ctl)
    );

    assign mem_rd     = ctl.mem_rd;
    assign mem_wr     = ctl.mem_wr;
    assign i_or_d     = ctl.i_or_d;
    assign ir_we      = ctl.ir_we;
    assign pc_we      = ctl.pc_we;
    assign pc_cond    = ctl.pc_cond;
    assign pc_src     = ctl.pc_src;
    assign src_a      = ctl.src_a;
    assign src_b      = ctl.src_b;
    assign alu_op     = ctl.alu_op;
    assign reg_we     = ctl.reg_we;
    assign reg_dst    = ctl.reg_dst;
    assign mem_to_reg = ctl.mem_to_reg;
    assign epc_we     = ctl.epc_we;
    assign cause_we   = ctl.cause_we;
    assign cause_code = ctl.cause_code;

    assert_mem_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_branch_last_R6: assert property (@(posedge clk) disable iff (rst)
        pc_cond |=> (mem_rd && ir_we));

    assert_wb_last_R5: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> (mem_rd && ir_we));

    assert_fn_decode_R11: assert property (@(posedge clk) disable iff (rst)
        (alu_op == AOP_SUB) |-> (alu_ctl == ACTL_SUB));

endmodule

// File: tb/mc_ctl_tb.sv
module mc_ctl_tb;

    logic clk = 1'b0;
    logic rst;
    logic [5:0] opcode, funct;
    logic ovf;
    logic mem_rd, mem_wr, i_or_d, ir_we, pc_we, pc_cond, src_a;
    logic reg_we, reg_dst, mem_to_reg, epc_we, cause_we, cause_code;
    logic [1:0] pc_src, src_b, alu_op;
    logic [3:0] alu_ctl;

    always #4 clk = ~clk;

    mc_ctl u_dut (
        .clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .ovf(ovf),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .i_or_d(i_or_d), .ir_we(ir_we),
        .pc_we(pc_we), .pc_cond(pc_cond), .pc_src(pc_src), .src_a(src_a),
        .src_b(src_b), .alu_op(alu_op), .alu_ctl(alu_ctl), .reg_we(reg_we),
        .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .epc_we(epc_we),
        .cause_we(cause_we), .cause_code(cause_code)
    );

    wire [18:0] got_vec = {mem_rd, mem_wr, i_or_d, ir_we, pc_we, pc_cond, pc_src,
                           src_a, src_b, alu_op, reg_we, reg_dst, mem_to_reg,
                           epc_we, cause_we, cause_code};

    localparam int B_F = 0, B_D = 1, B_MA = 2, B_MR = 3, B_MW = 4, B_SW = 5,
                   B_RX = 6, B_RW = 7, B_BR = 8, B_JP = 9, B_XU = 10, B_XO = 11;

    int n_run = 0;
    int n_fail = 0;

    function automatic logic [18:0] exp_vec(input int st);
        logic mrd = 0, mwr = 0, iod = 0, irw = 0, pcw = 0, pcc = 0, sa = 0;
        logic rw = 0, rd = 0, m2r = 0, ew = 0, cw = 0, cc = 0;
        logic [1:0] ps = 0, sb = 0, op = 0;
        case (st)
            B_F:  begin mrd = 1; irw = 1; pcw = 1; sb = 2'b01; end
            B_D:  begin sb = 2'b11; end
            B_MA: begin sa = 1; sb = 2'b10; end
            B_MR: begin mrd = 1; iod = 1; end
            B_MW: begin rw = 1; m2r = 1; end
            B_SW: begin mwr = 1; iod = 1; end
            B_RX: begin sa = 1; op = 2'b10; end
            B_RW: begin rw = 1; rd = 1; end
            B_BR: begin sa = 1; op = 2'b01; pcc = 1; ps = 2'b01; end
            B_JP: begin pcw = 1; ps = 2'b10; end
            B_XU, B_XO: begin
                ew = 1; cw = 1; pcw = 1; ps = 2'b11; sb = 2'b01; op = 2'b01;
                cc = (st == B_XO);
            end
            default: ;
        endcase
        return {mrd, mwr, iod, irw, pcw, pcc, ps, sa, sb, op, rw, rd, m2r, ew, cw, cc};
    endfunction

    function automatic logic [3:0] exp_alu(input logic [5:0] fn);
        case (fn)
            6'h22: return 4'b0110;
            6'h24: return 4'b0000;
            6'h25: return 4'b0001;
            6'h2A: return 4'b0111;
            default: return 4'b0010;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (opcode %h funct %h)", req, got, exp, opcode, funct);
        end
    endtask

    task automatic step(input string req, input int st);
        chk(req, {13'd0, got_vec}, {13'd0, exp_vec(st)});
        @(negedge clk);
        ovf = 1'($urandom);
    endtask

    task automatic run_instr(input logic [5:0] op, input logic [5:0] fn, input logic ov);
        opcode = op;
        funct  = fn;
        chk("R11 fetch alu", {28'd0, alu_ctl}, {28'd0, 4'b0010});
        step("R2 fetch", B_F);
        step("R3 decode", B_D);
        case (op)
            6'h23: begin
                step("R4 lw addr", B_MA);
                step("R4 lw read", B_MR);
                step("R4 lw writeback", B_MW);
            end
            6'h2B: begin
                step("R4 sw addr", B_MA);
                step("R4 sw write", B_SW);
            end
            6'h00: begin
                chk("R11 funct", {28'd0, alu_ctl}, {28'd0, exp_alu(fn)});
                chk("R5 exec", {13'd0, got_vec}, {13'd0, exp_vec(B_RX)});
                ovf = ov;
                @(negedge clk);
                if (ov) step("R10 overflow", B_XO);
                else    step("R5 writeback", B_RW);
            end
            6'h04: begin
                chk("R11 branch sub", {28'd0, alu_ctl}, {28'd0, 4'b0110});
                step("R6 branch", B_BR);
            end
            6'h02: step("R7 jump", B_JP);
            default: step("R9 undefined", B_XU);
        endcase
        chk("R8 back to fetch", {13'd0, got_vec}, {13'd0, exp_vec(B_F)});
    endtask

    function automatic logic [5:0] rand_undef();
        logic [5:0] v;
        do v = 6'($urandom);
        while (v == 6'h23 || v == 6'h2B || v == 6'h00 || v == 6'h04 || v == 6'h02);
        return v;
    endfunction

    function automatic logic [5:0] rand_fn();
        case ($urandom % 6)
            0: return 6'h20;
            1: return 6'h22;
            2: return 6'h24;
            3: return 6'h25;
            4: return 6'h2A;
            default: return 6'($urandom);
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog timeout");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; opcode = 6'h00; funct = 6'h20; ovf = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        chk("R1 reset state", {13'd0, got_vec}, {13'd0, exp_vec(B_F)});

        run_instr(6'h23, 6'h20, 1'b0);
        run_instr(6'h2B, 6'h20, 1'b0);
        run_instr(6'h00, 6'h20, 1'b0);
        run_instr(6'h00, 6'h22, 1'b1);
        run_instr(6'h00, 6'h2A, 1'b0);
        run_instr(6'h04, 6'h25, 1'b1);
        run_instr(6'h02, 6'h24, 1'b1);
        run_instr(6'h3F, 6'h20, 1'b0);
        run_instr(6'h05, 6'h20, 1'b1);

        opcode = 6'h23;
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R4 lw read before reset", {13'd0, got_vec}, {13'd0, exp_vec(B_MR)});
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset mid-instruction", {13'd0, got_vec}, {13'd0, exp_vec(B_F)});

        for (int i = 0; i < 400; i++) begin
            logic [5:0] op;
            case ($urandom % 7)
                0: op = 6'h23;
                1: op = 6'h2B;
                2: op = 6'h00;
                3: op = 6'h04;
                4: op = 6'h02;
                default: op = rand_undef();
            endcase
            run_instr(op, rand_fn(), 1'($urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule